// File: doc/BRIEF.md
# FIFO-Fed Burst Memory Write Engine

This block collects data words that a peripheral pushes into a local receive queue and writes them into system memory as one burst. It holds the system bus for the whole burst. When the queue holds at least a programmable number of words, a fill interrupt tells the host that data is waiting. The host then writes a destination address and a word count and issues a start command.

After the start command the engine raises one bus request and waits for the grant. While it holds the grant it issues one 32-bit write per memory cycle, taking data directly from the head of the queue. There is no read cycle, because the data is already local. Each write is held until memory acknowledges it. If the queue runs dry in the middle of a burst, the engine waits with the bus still held. An optional stall timer flags a long starvation. When the count reaches zero, the engine drops its request, sets a done flag and raises a done interrupt. Both stay set until the host clears them.

Top module: `burst_dma_wr`

## Requirements
- R1: After reset, bus_req, mem_wr, irq_fill and irq_done are low. The status word reads 0 and the threshold register reads DEPTH/2.
- R2: irq_fill is high exactly when the queue holds at least the threshold number of words. The threshold register sits at register offset 2 and can be rewritten at any time.
- R3: The registers are: offset 0 destination address, offset 1 length in words, offset 2 fill threshold, offset 3 control/status. A control write uses bit 0 for start, bit 1 to clear done and bit 2 to clear both error flags. A status read gives bit 0 busy, bit 1 done, bit 2 stall timeout and bit 3 start-while-busy. Offsets 0 and 1 read back the live address and the remaining count.
- R4: bus_req is high from the cycle after an accepted start until the cycle after the last acknowledged write. mem_wr is never high unless bus_gnt was sampled high in the previous cycle.
- R5: Each write carries the oldest queued word. The first write goes to the programmed address, and the address rises by 4 after each acknowledged write. Address and data hold steady while mem_wr waits for mem_ack.
- R6: Once the programmed number of writes have been acknowledged, bus_req drops, the done bit and irq_done rise, and the remaining count reads 0.
- R7: If the queue is empty during a burst, the engine keeps bus_req high, issues no write, and resumes when data arrives, with no word lost or repeated.
- R8: After STALL_LIMIT consecutive cycles with an empty queue during a burst, status bit 2 is set and the burst continues.
- R9: A start command while busy has no effect on the burst and sets status bit 3. Writes to the address and length registers while busy are ignored.
- R10: A control write with bit 1 clears the done bit and irq_done. A control write with bit 2 clears status bits 2 and 3.
- R11: A start command with a length of 0 sets done at once and never raises bus_req.
- R12: in_ready is low when the queue holds DEPTH words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Peripheral offers a word |
| in_data | input | DW | Peripheral word |
| in_ready | output | 1 | Queue can take a word |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Host register offset |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq_fill | output | 1 | Queue at or above threshold |
| irq_done | output | 1 | Burst completed, sticky |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| mem_wr | output | 1 | Memory write cycle active |
| mem_addr | output | AW | Write byte address |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Memory accepted the write |

## Verification
The hardest case to reach is starvation during a burst. The bus is granted, the queue is empty and the count is not yet zero, and this must last long enough to trip the stall timer. The stimulus gets there by queuing fewer words than the programmed length and then waiting past the limit before supplying the rest. Streaming runs push words with random gaps while memory acknowledges at random. This gives many short starvations and stretched cycles, and every accepted write is compared with the expected address and pushed word. A start command is also issued in the middle of a burst, together with address and length writes, to show they are ignored.

// File: rtl/bwr_pkg.sv
package bwr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARB  = 2'd1,
        ST_MOVE = 2'd2
    } bwr_state_e;

    localparam logic [1:0] RA_DST = 2'd0;
    localparam logic [1:0] RA_LEN = 2'd1;
    localparam logic [1:0] RA_THR = 2'd2;
    localparam logic [1:0] RA_CTL = 2'd3;

    localparam int CB_GO       = 0;
    localparam int CB_CLR_DONE = 1;
    localparam int CB_CLR_ERR  = 2;
endpackage

// File: rtl/bwr_fifo.sv
module bwr_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [DW-1:0]                din,
    input  logic                         pop,
    output logic [DW-1:0]                dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } fifo_t;

    fifo_t q, d;
    logic [DW-1:0] mem [DEPTH];
    logic push_ok, pop_ok;

    assign full    = (q.cnt == CNT_W'(DEPTH));
    assign empty   = (q.cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[q.rp];
    assign count   = q.cnt;

    always_comb begin
        d = q;
        if (push_ok) d.wp = (q.wp == PTR_W'(DEPTH-1)) ? '0 : q.wp + PTR_W'(1);
        if (pop_ok)  d.rp = (q.rp == PTR_W'(DEPTH-1)) ? '0 : q.rp + PTR_W'(1);
        if (push_ok && !pop_ok)      d.cnt = q.cnt + CNT_W'(1);
        else if (pop_ok && !push_ok) d.cnt = q.cnt - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[q.wp] <= din;
    end

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(DEPTH)); // R12
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full && $stable(q.wp)); // R12
endmodule

// File: rtl/bwr_stall_timer.sv
module bwr_stall_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT+1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        if (!run)                     cnt_d = '0;
        else if (cnt_q == CW'(LIMIT)) cnt_d = cnt_q;
        else                          cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == CW'(LIMIT));

    AST_TIMER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !expired); // R8
endmodule

// File: rtl/burst_dma_wr.sv
module burst_dma_wr
    import bwr_pkg::*;
#(
    parameter int DW          = 32,
    parameter int AW          = 32,
    parameter int DEPTH       = 16,
    parameter int LEN_W       = 16,
    parameter int STALL_LIMIT = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          irq_fill,
    output logic          irq_done,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack
);
    localparam int CNT_W  = $clog2(DEPTH+1);
    localparam int STEP_B = DW / 8;

    typedef struct packed {
        bwr_state_e       st;
        logic [AW-1:0]    addr;
        logic [LEN_W-1:0] len;
        logic [CNT_W-1:0] thr;
        logic             done;
        logic             terr;
        logic             gerr;
    } eng_t;

    eng_t q, d;

    logic [DW-1:0]    f_dout;
    logic [CNT_W-1:0] f_count;
    logic             f_full, f_empty;
    logic             busy, beat, accept, go_cmd, stall_run, stall_hit;

    bwr_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (in_valid),
        .din   (in_data),
        .pop   (accept),
        .dout  (f_dout),
        .count (f_count),
        .full  (f_full),
        .empty (f_empty)
    );

    assign stall_run = (q.st == ST_MOVE) && f_empty;

    generate
        if (STALL_LIMIT > 0) begin : g_timer
            bwr_stall_timer #(.LIMIT(STALL_LIMIT)) u_timer (
                .clk     (clk),
                .rst_n   (rst_n),
                .run     (stall_run),
                .expired (stall_hit)
            );
        end else begin : g_no_timer
            assign stall_hit = 1'b0;
        end
    endgenerate

    assign busy    = (q.st != ST_IDLE);
    assign beat    = (q.st == ST_MOVE) && !f_empty && bus_gnt;
    assign accept  = beat && mem_ack;
    assign go_cmd  = reg_wr && (reg_addr == RA_CTL) && reg_wdata[CB_GO];

    always_comb begin
        d = q;
        // host register writes
        if (reg_wr) begin
            case (reg_addr)
                RA_DST: if (!busy) d.addr = reg_wdata[AW-1:0];
                RA_LEN: if (!busy) d.len  = reg_wdata[LEN_W-1:0];
                RA_THR: d.thr = reg_wdata[CNT_W-1:0];
                default: begin
                    if (reg_wdata[CB_CLR_DONE]) d.done = 1'b0;
                    if (reg_wdata[CB_CLR_ERR]) begin
                        d.terr = 1'b0;
                        d.gerr = 1'b0;
                    end
                end
            endcase
        end
        if (go_cmd && busy) d.gerr = 1'b1;
        if (stall_hit)      d.terr = 1'b1;
        // transfer sequencing
        case (q.st)
            ST_IDLE: begin
                if (go_cmd) begin
                    if (q.len == '0) d.done = 1'b1;
                    else             d.st   = ST_ARB;
                end
            end
            ST_ARB: begin
                if (bus_gnt) d.st = ST_MOVE;
            end
            ST_MOVE: begin
                if (accept) begin
                    d.addr = q.addr + AW'(STEP_B);
                    d.len  = q.len - LEN_W'(1);
                    if (q.len == LEN_W'(1)) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.thr  <= CNT_W'(DEPTH / 2);
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (reg_addr)
            RA_DST:  reg_rdata = 32'(q.addr);
            RA_LEN:  reg_rdata = 32'(q.len);
            RA_THR:  reg_rdata = 32'(q.thr);
            default: reg_rdata = {28'd0, q.gerr, q.terr, q.done, busy};
        endcase
    end

    assign in_ready  = !f_full;
    assign irq_fill  = (f_count >= q.thr);
    assign irq_done  = q.done;
    assign bus_req   = busy;
    assign mem_wr    = beat;
    assign mem_addr  = q.addr;
    assign mem_wdata = f_dout;

    AST_WR_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> bus_req); // R4
    AST_WR_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(bus_gnt)); // R4
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_wdata))); // R5
    AST_LEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && mem_ack) |=> (q.len == $past(q.len) - LEN_W'(1))); // R6
    AST_REQ_DROP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> irq_done); // R6
    AST_STALL_HOLDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        stall_run |=> bus_req); // R7
    AST_GO_BUSY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (go_cmd && busy) |=> reg_rdata[3] || reg_addr != RA_CTL || q.gerr); // R9
    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (go_cmd && !busy && q.len == '0) |=> (!bus_req && irq_done)); // R11
endmodule

// File: tb/burst_dma_wr_test.sv
module burst_dma_wr_test;
    localparam int DEPTH = 16;
    localparam int STALL = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_fill, irq_done, bus_req, mem_wr;
    logic        bus_gnt = 1'b0;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata;

    int tests = 0;
    int fails = 0;
    logic [31:0] push_log [4096];
    int push_n = 0;
    int wr_total = 0;
    int xfer_first = 0;
    logic [31:0] exp_base = '0;
    int ack_pct = 100;
    int gnt_wait = 0;

    always #5 clk = ~clk;

    burst_dma_wr #(.DEPTH(DEPTH), .STALL_LIMIT(STALL)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_fill(irq_fill),
        .irq_done(irq_done), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack)
    );

    function automatic logic [31:0] exp_addr(input logic [31:0] base, input int k);
        return base + 32'(4 * k);
    endfunction

    function automatic bit exp_fill(input int cnt, input int thr);
        return cnt >= thr;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_tb();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // memory and arbiter model, decisions made away from the clock edge
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
            bus_gnt = 1'b0;
        end else begin
            if (mem_wr && (int'($urandom % 100) < ack_pct)) begin
                mem_ack = 1'b1;
                check(wr_total < push_n, "R7 write without pushed word", 32'(wr_total), 32'(push_n));
                check(mem_addr == exp_addr(exp_base, wr_total - xfer_first),
                      "R5 write address", mem_addr, exp_addr(exp_base, wr_total - xfer_first));
                check(mem_wdata == push_log[wr_total], "R5 write data",
                      mem_wdata, push_log[wr_total]);
                wr_total++;
            end else begin
                mem_ack = 1'b0;
            end
            if (!bus_req) begin
                bus_gnt = 1'b0;
                gnt_wait = int'($urandom % 4);
            end else if (!bus_gnt) begin
                if (gnt_wait == 0) bus_gnt = 1'b1;
                else gnt_wait--;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=%0d expected=done", tests);
        finish_tb();
    end

    task automatic reg_write(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic push_words(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            repeat (int'($urandom % (gap + 1))) @(negedge clk);
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_data = $urandom;
            push_log[push_n] = in_data;
            push_n++;
            @(posedge clk);
            #1 in_valid = 1'b0;
        end
    endtask

    task automatic wait_done();
        logic [31:0] v;
        int n = 0;
        do begin
            reg_read(2'd3, v);
            n++;
        end while (!v[1] && n < 20000);
    endtask

    task automatic run_xfer(input logic [31:0] base, input int len, input int npush,
                            input int gap, input bit poke);
        logic [31:0] v;
        reg_write(2'd0, base);
        reg_read(2'd0, v);
        check(v == base, "R3 address readback", v, base);
        reg_write(2'd1, 32'(len));
        exp_base = base;
        xfer_first = wr_total;
        fork
            push_words(npush, gap);
            begin
                reg_write(2'd3, 32'h1);
                if (poke) begin
                    repeat (2) @(negedge clk);
                    reg_write(2'd3, 32'h1);
                    reg_write(2'd0, 32'hDEAD_0000);
                    reg_write(2'd1, 32'd5);
                    reg_read(2'd3, v);
                    check(v[3] == 1'b1, "R9 start-while-busy flag", v, 32'h8);
                end
                wait_done();
            end
        join
        check(wr_total - xfer_first == len, "R6 write count", 32'(wr_total - xfer_first), 32'(len));
        reg_read(2'd1, v);
        check(v == 0, "R6 remaining length", v, 0);
        reg_read(2'd0, v);
        check(v == exp_addr(base, len), "R5 final address", v, exp_addr(base, len));
        check(bus_req == 1'b0, "R6 bus released", 32'(bus_req), 0);
        check(irq_done == 1'b1, "R6 done interrupt", 32'(irq_done), 1);
        reg_write(2'd3, 32'h2);
        reg_read(2'd3, v);
        check(v[1] == 1'b0 && irq_done == 1'b0, "R10 clear done", v, 0);
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(2'd3, v);
        check(v == 0, "R1 status after reset", v, 0);
        reg_read(2'd2, v);
        check(v == DEPTH / 2, "R1 threshold after reset", v, DEPTH / 2);
        check(!bus_req && !mem_wr && !irq_fill && !irq_done, "R1 outputs low",
              {bus_req, mem_wr, irq_fill, irq_done}, 0);

        // R2 fill interrupt
        push_words(DEPTH / 2 - 1, 0);
        @(negedge clk);
        check(irq_fill == exp_fill(DEPTH / 2 - 1, DEPTH / 2), "R2 below threshold", 32'(irq_fill), 0);
        push_words(1, 0);
        @(negedge clk);
        check(irq_fill == exp_fill(DEPTH / 2, DEPTH / 2), "R2 at threshold", 32'(irq_fill), 1);
        reg_write(2'd2, 32'd9);
        check(irq_fill == exp_fill(DEPTH / 2, 9), "R2 raised threshold", 32'(irq_fill), 0);
        reg_write(2'd2, 32'd3);
        check(irq_fill == exp_fill(DEPTH / 2, 3), "R2 lowered threshold", 32'(irq_fill), 1);
        reg_write(2'd2, 32'(DEPTH / 2));

        // R12 full queue
        push_words(DEPTH / 2, 0);
        @(negedge clk);
        check(in_ready == 1'b0, "R12 ready low when full", 32'(in_ready), 0);

        // drain a full queue with slow memory
        ack_pct = 40;
        run_xfer(32'h0001_0000, DEPTH, 0, 0, 1'b0);

        // R9 start and register writes while busy
        ack_pct = 70;
        run_xfer(32'h0002_0100, 30, 30, 2, 1'b1);

        // R7 R8 starvation with bus held
        ack_pct = 100;
        reg_write(2'd3, 32'h4);
        reg_write(2'd0, 32'h0003_0000);
        reg_write(2'd1, 32'd4);
        exp_base = 32'h0003_0000;
        xfer_first = wr_total;
        push_words(2, 0);
        reg_write(2'd3, 32'h1);
        check(bus_req == 1'b1, "R4 request after start", 32'(bus_req), 1);
        for (int i = 0; i < 200 && (wr_total - xfer_first) < 2; i++) @(negedge clk);
        repeat (STALL / 2) @(negedge clk);
        reg_read(2'd3, v);
        check(v[2] == 1'b0, "R8 no timeout before limit", v, 0);
        repeat (STALL + 4) @(negedge clk);
        reg_read(2'd3, v);
        check(v[2] == 1'b1, "R8 timeout flag", v, 32'h4);
        check(bus_req == 1'b1, "R7 bus kept while starved", 32'(bus_req), 1);
        check(wr_total - xfer_first == 2, "R7 no write while empty", 32'(wr_total - xfer_first), 2);
        push_words(2, 0);
        wait_done();
        check(wr_total - xfer_first == 4, "R7 resume after starvation", 32'(wr_total - xfer_first), 4);
        reg_write(2'd3, 32'h6);
        reg_read(2'd3, v);
        check(v[3:1] == 3'b000, "R10 clear error flags", v, 0);

        // R11 zero length
        reg_write(2'd1, 32'd0);
        reg_write(2'd3, 32'h1);
        reg_read(2'd3, v);
        check(v[1] == 1'b1 && bus_req == 1'b0, "R11 zero length done", v, 32'h2);
        repeat (5) @(negedge clk);
        check(bus_req == 1'b0, "R11 no request", 32'(bus_req), 0);
        reg_write(2'd3, 32'h2);

        // random streaming bursts
        for (int r = 0; r < 8; r++) begin
            int len;
            len = 1 + int'($urandom % 40);
            ack_pct = 40 + int'($urandom % 61);
            run_xfer({$urandom} & 32'hFFFF_FFFC, len, len, int'($urandom % 4), 1'b0);
        end

        finish_tb();
    end
endmodule